// File: doc/BRIEF.md
# Packing Saturating Channel Counter

One channel of a multi-channel pulse counting array. An asynchronous pulse line is brought into the system clock domain by a two-stage catcher. The first stage is clocked by the pulse itself. The second stage samples it on the system clock and clears the first stage asynchronously. Each captured event adds one to a saturating window counter.

A shared controller drives the same window-end strobe, format select, enable and clear into every channel, so all channels run in lockstep. At each window end the closing count is clamped to the width of its field and placed in a shadow word. Depending on the format, a word holds one, two or four consecutive window results. When the word is full, it is copied to a registered output and flagged valid for one cycle. The next window starts counting on that same edge, so there is no dead time.

Top module: `pulse_pack_counter`

## Requirements
- R1: Input events are captured at no more than one every two clock cycles. When a second rising edge arrives while the previous event is still being taken in, it is lost.
- R2: Every captured event is counted in exactly one window. The window-end strobe is sampled at a clock edge. An event taken in on that same edge belongs to the new window, which then starts at 1.
- R3: With fmt = 0, each window end produces one word. The word carries the window count in bits CNT_W-1:0, and all bits above are zero.
- R4: With fmt = 1, two windows make one word. The earlier window's result is in bits 15:0 and the later window's result is in bits 31:16.
- R5: With fmt = 2, four windows make one word. The first window's result is in bits 7:0, and later results follow in bits 15:8, 23:16 and 31:24.
- R6: A window result larger than its field can hold (65535 for a 16-bit field, 255 for an 8-bit field) is stored as that maximum, never wrapped.
- R7: The window counter stops at 2^CNT_W-1 and holds there until the window ends.
- R8: word_vld is high for exactly the one cycle after the window-end edge that completes a word. word_out keeps its value until the next word completes.
- R9: While en is low, input events and window-end strobes have no effect on the count, the packing position or the output.
- R10: clr resets the window count, the packing position, the partial word and word_vld. The last completed word stays on word_out.
- R11: fmt = 3 behaves exactly like fmt = 0.
- R12: After reset, word_out is zero and word_vld is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears count, packing position and valid flag |
| en | input | 1 | Enables counting and window ends |
| pulse_in | input | 1 | Asynchronous event input |
| win_end | input | 1 | Window-end strobe, one cycle |
| fmt | input | 2 | Packing format: 0 one result, 1 two 16-bit, 2 four 8-bit, 3 as 0 |
| word_out | output | WORD_W | Last completed packed word |
| word_vld | output | 1 | One-cycle flag that a new word is on word_out |

## Verification
The assertions assume that fmt changes only while the packing position is zero, which means right after a clear or after a completed word. They also assume that pulse_in rises well away from the clock edge. The stimulus changes fmt only after a clear or on a word boundary. It raises pulse_in 2 ns after a rising clock edge and drops it 3 ns later. The bench uses a 10-bit counter so that counter saturation can be reached. It also drives pulses on back-to-back cycles so that the capture rate limit comes into play.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    FMT_ONE  = 2'd0,
    FMT_TWO  = 2'd1,
    FMT_FOUR = 2'd2,
    FMT_ALT  = 2'd3
  } fmt_e;

  // log2 of the number of results per word
  function automatic int unsigned pack_shift(input logic [1:0] f);
    case (f)
      FMT_TWO:  return 1;
      FMT_FOUR: return 2;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/edge_catch.sv
module edge_catch (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic ev
);
  logic catch_q;
  logic ev_q;
  logic rst_q;
  logic catch_clr;

  always_ff @(posedge clk) rst_q <= rst;

  assign catch_clr = ev_q | rst_q;

  // first stage: clocked by the event itself, cleared by the second stage
  always_ff @(posedge pulse_in or posedge catch_clr) begin
    if (catch_clr) catch_q <= 1'b0;
    else           catch_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= 1'b0;
    else     ev_q <= catch_q;
  end

  assign ev = ev_q;

  // R1
  ev_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
endmodule

// File: rtl/win_counter.sv
module win_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             ev,
  input  logic             win_end,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (win_end)                 cnt_q <= {{(CNT_W-1){1'b0}}, ev};
      else if (ev && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !win_end && !clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !win_end && !clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/word_packer.sv
module word_packer
  import ppc_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              boundary,
  input  logic [1:0]        fmt,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int SLOT_W = 2;

  logic [WORD_W-1:0] shadow_q, word_q;
  logic [SLOT_W-1:0] slot_q, last_slot;
  logic              vld_q;
  logic [WORD_W-1:0] cnt_ext, fmax, field, placed;
  int unsigned       sh, fw;

  always_comb begin
    sh        = pack_shift(fmt);
    fw        = WORD_W >> sh;
    last_slot = SLOT_W'((1 << sh) - 1);
    cnt_ext   = WORD_W'(cnt);
    fmax      = (fw >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << fw) - 1'b1);
    field     = (cnt_ext > fmax) ? fmax : cnt_ext;
    placed    = field << (int'(slot_q) * int'(fw));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      word_q   <= '0;
      slot_q   <= '0;
      vld_q    <= 1'b0;
    end else if (clr) begin
      shadow_q <= '0;
      slot_q   <= '0;
      vld_q    <= 1'b0;
    end else if (boundary) begin
      if (slot_q == last_slot) begin
        word_q   <= shadow_q | placed;
        shadow_q <= '0;
        slot_q   <= '0;
        vld_q    <= 1'b1;
      end else begin
        shadow_q <= shadow_q | placed;
        slot_q   <= slot_q + 1'b1;
        vld_q    <= 1'b0;
      end
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign word_out = word_q;
  assign word_vld = vld_q;

  // R8
  vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(boundary));

  // R3
  one_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && ($past(fmt) == FMT_ONE)) |-> ((word_out >> CNT_W) == '0));

  // R10
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!word_vld && slot_q == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out) || $past(rst));
endmodule

// File: rtl/pulse_pack_counter.sv
module pulse_pack_counter #(
  parameter int CNT_W  = 23,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              pulse_in,
  input  logic              win_end,
  input  logic [1:0]        fmt,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  logic             ev;
  logic [CNT_W-1:0] cnt;
  logic             boundary;

  assign boundary = en && win_end && !clr;

  edge_catch u_catch (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .ev       (ev)
  );

  win_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .en      (en),
    .ev      (ev),
    .win_end (win_end),
    .cnt     (cnt)
  );

  word_packer #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .boundary (boundary),
    .fmt      (fmt),
    .cnt      (cnt),
    .word_out (word_out),
    .word_vld (word_vld)
  );
endmodule

// File: tb/pulse_pack_counter_test.sv
`timescale 1ns/1ps
module pulse_pack_counter_test;
  localparam int CW = 10;
  localparam int WW = 32;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, en = 1'b1, pulse_in = 1'b0, win_end = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [WW-1:0] word_out;
  logic word_vld;

  int errors = 0, checks = 0;
  bit done = 0;
  string req = "R12";

  // model state
  int  mcnt = 0, mslot = 0;
  bit  mb = 0, evld = 0;
  logic [WW-1:0] msh = '0, eword = '0;

  pulse_pack_counter #(.CNT_W(CW), .WORD_W(WW)) uut (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .pulse_in(pulse_in),
    .win_end(win_end), .fmt(fmt), .word_out(word_out), .word_vld(word_vld)
  );

  always #5 clk = ~clk;

  task automatic chk(input string r, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit p, input bit w);
    int close, sh, fw, fv, n;
    close = 0;
    if (clr) begin
      mcnt = 0; mslot = 0; msh = '0; evld = 0;
    end else begin
      evld = 0;
      if (en) begin
        if (w) begin
          close = mcnt;
          mcnt  = mb ? 1 : 0;
          sh = (fmt == 2'd1) ? 1 : (fmt == 2'd2) ? 2 : 0;
          n  = 1 << sh;
          fw = WW >> sh;
          fv = (fw < 31 && close > (1 << fw) - 1) ? (1 << fw) - 1 : close;
          msh = msh | (WW'(fv) << (mslot * fw));
          if (mslot == n - 1) begin
            eword = msh; msh = '0; mslot = 0; evld = 1;
          end else mslot++;
        end else if (mb && mcnt < CMAX) mcnt++;
      end
    end
    mb = p && !mb;
  endtask

  // called at posedge+2; returns at next posedge+2
  task automatic cyc(input bit p, input bit w);
    win_end = w;
    if (p) begin pulse_in = 1'b1; #3; pulse_in = 1'b0; end
    else #3;
    @(posedge clk);
    model_edge(p, w);
    #1;
    chk(req, {31'd0, word_vld}, {31'd0, evld});
    chk(req, word_out, eword);
    #1;
  endtask

  task automatic run_win(input int len, input int k);
    for (int i = 0; i < len; i++)
      cyc((k > 0) && (i % k == 0), i == len - 1);
  endtask

  task automatic do_clr();
    clr = 1'b1; cyc(0, 0); clr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    @(posedge clk); #1;
    // R12 reset state
    chk("R12", word_out, '0);
    chk("R12", {31'd0, word_vld}, 32'd0);
    #1;
    // R3 single result per word, varied densities
    req = "R3";
    run_win(10, 2); run_win(25, 3); run_win(7, 0); run_win(40, 5);
    // R1 pulses on every cycle: only every other captured
    req = "R1";
    run_win(30, 1); run_win(11, 1);
    // R2 event landing on the boundary edge goes to the next window
    req = "R2";
    for (int i = 0; i < 12; i++) cyc(i == 10, i == 11);
    run_win(6, 0);
    for (int i = 0; i < 9; i++) cyc(i == 7 || i == 2, i == 8);
    // R4 two 16-bit results
    req = "R4"; do_clr(); fmt = 2'd1;
    run_win(20, 2); run_win(9, 3); run_win(15, 4); run_win(31, 1);
    // R5 four 8-bit results
    req = "R5"; do_clr(); fmt = 2'd2;
    run_win(8, 2); run_win(14, 3); run_win(5, 0); run_win(22, 2);
    run_win(3, 1); run_win(17, 4); run_win(12, 2); run_win(9, 1);
    // R6 8-bit field clamp (300 events) then small windows
    req = "R6";
    run_win(600, 2); run_win(10, 2); run_win(520, 2); run_win(4, 0);
    // R7 counter saturation in single-result mode
    req = "R7"; do_clr(); fmt = 2'd0;
    run_win(2200, 2); run_win(10, 2);
    // R6 16-bit field: counter cap below field max
    req = "R6"; fmt = 2'd1;
    run_win(2100, 2); run_win(8, 2);
    // R8 word held between completions
    req = "R8";
    run_win(6, 2); for (int i = 0; i < 5; i++) cyc(0, 0); run_win(10, 3);
    // R9 enable low: pulses and window ends ignored
    req = "R9"; do_clr(); fmt = 2'd2;
    run_win(9, 2);
    en = 1'b0; run_win(12, 2); run_win(5, 1); en = 1'b1;
    run_win(7, 0); run_win(10, 2); run_win(6, 3);
    // R10 clear mid-word
    req = "R10";
    run_win(8, 2); run_win(5, 2);
    for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 0);
    do_clr();
    run_win(10, 2); run_win(4, 2); run_win(6, 3); run_win(8, 2);
    // R11 format 3 as single result
    req = "R11"; do_clr(); fmt = 2'd3;
    run_win(13, 2); run_win(2200, 2); run_win(5, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule